// File: doc/BRIEF.md
# Write-Burst to Stream Bridge

This block is a memory-mapped write slave that turns each incoming write burst into one framed stream packet. A burst is described on the write address channel by a beat count, a beat size, a burst type and a tag. The data beats, each with byte strobes and an end flag, come in on the write data channel. Each beat is sent out on a stream master port. The stream data equals the write data, the stream keep mask equals the byte strobes, and the stream end marker is raised on the beat that completes the counted burst. When the last beat has left, the block gives one write response that carries the burst's tag.

Write data may arrive before its address. Such beats wait in a small buffer and go out only after the address has been taken. The bridge handles one burst at a time. Stall on the stream side fills the buffer and then holds off the write data channel. No beat is lost or reordered. The block does no address decoding and has no storage target, so the address value itself is not a port.

Top module: `axw_wr2stream`

## Requirements
- R1: A transfer happens on a channel only in a cycle where that channel's valid and ready are both high. Each channel's ready (aw_ready, w_ready, s_ready, b_ready) is taken into account only in that cycle.
- R2: Write data beats are accepted before their address is taken, up to FIFO_DEPTH beats (default 4). While FIFO_DEPTH beats are held, w_ready is low.
- R3: s_valid stays low while no burst address has been accepted (aw_ready high). Buffered beats are not forwarded until the address handshake.
- R4: Every stream beat carries s_data equal to w_data and s_keep equal to w_strb of the matching input beat, with one strobe bit per byte and bit i covering bits 8i+7..8i. Sparse patterns such as 8'h19 (bytes 0, 3 and 4) come through unchanged, and beat order is preserved.
- R5: A burst with aw_len = N produces exactly N+1 stream beats. s_last is high on the (N+1)-th beat only, whatever w_last says.
- R6: b_valid rises in the cycle after the final beat of a burst is taken on the stream port, and not earlier. A well-formed burst answers OKAY = 2'b00.
- R7: The response is SLVERR = 2'b10 in three cases: w_last disagrees with the counted position on any beat, aw_size exceeds log2 of the bus bytes (3 for 64 bits), or aw_burst is the reserved code 2'b11. The burst is still run to its counted length.
- R8: Only one burst is open at a time. aw_ready is low from the address handshake until the response handshake, and it is high again in the next cycle.
- R9: With s_ready low, s_valid, s_data, s_keep and s_last hold. Once the buffer is full, w_ready falls and no beat is lost.
- R10: b_id equals the aw_id of the burst. b_valid, b_resp and b_id hold until b_ready.
- R11: After reset, aw_ready and w_ready are high and s_valid and b_valid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| aw_valid | input | 1 | Address channel valid |
| aw_ready | output | 1 | Address channel ready |
| aw_len | input | 8 | Beats minus one |
| aw_size | input | 3 | log2 of bytes per beat |
| aw_burst | input | 2 | Burst type |
| aw_id | input | ID_W | Burst tag |
| w_valid | input | 1 | Data channel valid |
| w_ready | output | 1 | Data channel ready |
| w_data | input | DATA_W | Write data |
| w_strb | input | DATA_W/8 | Byte strobes |
| w_last | input | 1 | Sender's end-of-burst flag |
| s_valid | output | 1 | Stream valid |
| s_ready | input | 1 | Stream ready |
| s_data | output | DATA_W | Stream data |
| s_keep | output | DATA_W/8 | Stream byte keep mask |
| s_last | output | 1 | Stream end of packet |
| b_valid | output | 1 | Response valid |
| b_ready | input | 1 | Response ready |
| b_resp | output | 2 | Response code |
| b_id | output | ID_W | Response tag |

## Verification
Every output is a function of registered state only. A handshake at one edge therefore shows its effect in the very next cycle. A beat taken on the data channel can be on the stream port one cycle later if its address is already in. An address handshake opens the stream output one cycle later. The final stream beat raises b_valid one cycle later, and the response handshake raises aw_ready one cycle later. The bench advances a queue-based model at each rising edge on the same handshakes and compares all ready and valid outputs against it at the following falling edge. Stream beats and responses are compared at the edge where they fire against lists built from the burst scripts. The burst scripts cover address-late bursts, sparse strobes, bad end flags, bad attributes and random stall on every channel.

// File: rtl/axw_pkg.sv
package axw_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MOVE = 2'd1,
        ST_RESP = 2'd2
    } ctl_state_t;

    localparam logic [1:0] RESP_OKAY   = 2'b00;
    localparam logic [1:0] RESP_SLVERR = 2'b10;
    localparam logic [1:0] BURST_RSVD  = 2'b11;

    typedef struct packed {
        logic [7:0] len;
        logic       attr_bad;
    } burst_desc_t;

    function automatic logic attr_is_bad(input logic [2:0] size,
                                         input logic [1:0] btype,
                                         input int unsigned bytes_log2);
        return (int'(unsigned'(size)) > int'(bytes_log2)) || (btype == BURST_RSVD);
    endfunction

endpackage

// File: rtl/axw_beat_fifo.sv
module axw_beat_fifo #(
    parameter int W     = 73,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full  = (count == CW'(DEPTH));
    assign empty = (count == '0);
    assign dout  = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= nxt(wr_ptr);
            end
            if (pop) begin
                rd_ptr <= nxt(rd_ptr);
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= din;
        end
    end

endmodule

// File: rtl/axw_burst_ctl.sv
module axw_burst_ctl
    import axw_pkg::*;
#(
    parameter int ID_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            aw_fire,
    input  burst_desc_t     aw_desc,
    input  logic [ID_W-1:0] aw_tag,
    input  logic            beat_fire,
    input  logic            beat_wlast,
    input  logic            b_ready,
    output logic            aw_open,
    output logic            move_en,
    output logic            last_now,
    output logic            b_valid,
    output logic [1:0]      b_resp,
    output logic [ID_W-1:0] b_id
);
    ctl_state_t      state;
    logic [7:0]      beat_cnt;
    logic [7:0]      len_q;
    logic            err_q;
    logic [ID_W-1:0] tag_q;

    assign aw_open  = (state == ST_IDLE);
    assign move_en  = (state == ST_MOVE);
    assign b_valid  = (state == ST_RESP);
    assign last_now = (beat_cnt == len_q);
    assign b_resp   = err_q ? RESP_SLVERR : RESP_OKAY;
    assign b_id     = tag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            beat_cnt <= '0;
            len_q    <= '0;
            err_q    <= 1'b0;
            tag_q    <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (aw_fire) begin
                        len_q    <= aw_desc.len;
                        err_q    <= aw_desc.attr_bad;
                        tag_q    <= aw_tag;
                        beat_cnt <= '0;
                        state    <= ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    if (beat_fire) begin
                        if (beat_wlast != last_now) begin
                            err_q <= 1'b1;
                        end
                        if (last_now) begin
                            state <= ST_RESP;
                        end else begin
                            beat_cnt <= beat_cnt + 1'b1;
                        end
                    end
                end
                ST_RESP: begin
                    if (b_ready) begin
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/axw_wr2stream.sv
module axw_wr2stream
    import axw_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int ID_W       = 4,
    parameter int FIFO_DEPTH = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                aw_valid,
    output logic                aw_ready,
    input  logic [7:0]          aw_len,
    input  logic [2:0]          aw_size,
    input  logic [1:0]          aw_burst,
    input  logic [ID_W-1:0]     aw_id,
    input  logic                w_valid,
    output logic                w_ready,
    input  logic [DATA_W-1:0]   w_data,
    input  logic [DATA_W/8-1:0] w_strb,
    input  logic                w_last,
    output logic                s_valid,
    input  logic                s_ready,
    output logic [DATA_W-1:0]   s_data,
    output logic [DATA_W/8-1:0] s_keep,
    output logic                s_last,
    output logic                b_valid,
    input  logic                b_ready,
    output logic [1:0]          b_resp,
    output logic [ID_W-1:0]     b_id
);
    localparam int STRB_W     = DATA_W / 8;
    localparam int BYTES_LOG2 = $clog2(STRB_W);
    localparam int BEAT_W     = DATA_W + STRB_W + 1;

    logic              fifo_full, fifo_empty;
    logic [BEAT_W-1:0] head;
    logic              push, pop;
    logic              move_en, last_now;
    logic              head_wlast;
    burst_desc_t       desc;

    assign w_ready = !fifo_full;
    assign push    = w_valid && w_ready;
    assign s_valid = move_en && !fifo_empty;
    assign pop     = s_valid && s_ready;

    assign desc.len      = aw_len;
    assign desc.attr_bad = attr_is_bad(aw_size, aw_burst, BYTES_LOG2);

    axw_beat_fifo #(
        .W     (BEAT_W),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   ({w_data, w_strb, w_last}),
        .full  (fifo_full),
        .pop   (pop),
        .dout  (head),
        .empty (fifo_empty)
    );

    assign s_data     = head[BEAT_W-1 -: DATA_W];
    assign s_keep     = head[STRB_W:1];
    assign head_wlast = head[0];
    assign s_last     = last_now;

    axw_burst_ctl #(
        .ID_W (ID_W)
    ) u_ctl (
        .clk        (clk),
        .rst        (rst),
        .aw_fire    (aw_valid && aw_ready),
        .aw_desc    (desc),
        .aw_tag     (aw_id),
        .beat_fire  (pop),
        .beat_wlast (head_wlast),
        .b_ready    (b_ready),
        .aw_open    (aw_ready),
        .move_en    (move_en),
        .last_now   (last_now),
        .b_valid    (b_valid),
        .b_resp     (b_resp),
        .b_id       (b_id)
    );

endmodule

// File: rtl/axw_wr2stream_chk.sv
module axw_wr2stream_chk #(
    parameter int DATA_W = 64,
    parameter int ID_W   = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                aw_ready,
    input logic                s_valid,
    input logic                s_ready,
    input logic [DATA_W-1:0]   s_data,
    input logic [DATA_W/8-1:0] s_keep,
    input logic                s_last,
    input logic                b_valid,
    input logic                b_ready,
    input logic [1:0]          b_resp,
    input logic [ID_W-1:0]     b_id
);
    a_r3_quiet_idle: assert property (@(posedge clk) disable iff (rst)
        aw_ready |-> !s_valid);

    a_r8_single_burst: assert property (@(posedge clk) disable iff (rst)
        b_valid |-> !aw_ready);

    a_r8_reopen: assert property (@(posedge clk) disable iff (rst)
        (b_valid && b_ready) |=> aw_ready);

    a_r9_stream_hold: assert property (@(posedge clk) disable iff (rst)
        (s_valid && !s_ready) |=> (s_valid && $stable(s_data) && $stable(s_keep) && $stable(s_last)));

    a_r6_resp_after_last: assert property (@(posedge clk) disable iff (rst)
        $rose(b_valid) |-> $past(s_valid && s_ready && s_last));

    a_r10_resp_hold: assert property (@(posedge clk) disable iff (rst)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_resp) && $stable(b_id)));
endmodule

bind axw_wr2stream axw_wr2stream_chk #(
    .DATA_W (DATA_W),
    .ID_W   (ID_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .aw_ready (aw_ready),
    .s_valid  (s_valid),
    .s_ready  (s_ready),
    .s_data   (s_data),
    .s_keep   (s_keep),
    .s_last   (s_last),
    .b_valid  (b_valid),
    .b_ready  (b_ready),
    .b_resp   (b_resp),
    .b_id     (b_id)
);

// File: tb/sim_axw_wr2stream.sv
module sim_axw_wr2stream;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 64;
    localparam int SW = DW / 8;
    localparam int IW = 4;
    localparam int DEPTH = 4;

    typedef struct {
        logic [DW-1:0] d;
        logic [SW-1:0] k;
        logic          l;
    } beat_t;
    typedef struct {
        logic [7:0]    len;
        logic [2:0]    size;
        logic [1:0]    bt;
        logic [IW-1:0] id;
    } aw_t;
    typedef struct {
        logic [1:0]    resp;
        logic [IW-1:0] id;
    } b_t;

    logic clk = 0, rst = 1;
    logic aw_valid = 0, aw_ready;
    logic [7:0] aw_len = 0;
    logic [2:0] aw_size = 0;
    logic [1:0] aw_burst = 0;
    logic [IW-1:0] aw_id = 0;
    logic w_valid = 0, w_ready;
    logic [DW-1:0] w_data = 0;
    logic [SW-1:0] w_strb = 0;
    logic w_last = 0;
    logic s_valid, s_ready = 0, s_last;
    logic [DW-1:0] s_data;
    logic [SW-1:0] s_keep;
    logic b_valid, b_ready = 0;
    logic [1:0] b_resp;
    logic [IW-1:0] b_id;

    axw_wr2stream #(.DATA_W(DW), .ID_W(IW), .FIFO_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst),
        .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_len(aw_len), .aw_size(aw_size),
        .aw_burst(aw_burst), .aw_id(aw_id),
        .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data), .w_strb(w_strb), .w_last(w_last),
        .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data), .s_keep(s_keep), .s_last(s_last),
        .b_valid(b_valid), .b_ready(b_ready), .b_resp(b_resp), .b_id(b_id)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int total = 0, bad = 0, cyc = 0;
    beat_t wq[$];  aw_t aq[$];  beat_t es[$];  b_t eb[$];
    int wi = 0, ai = 0, b_done = 0;
    bit w_acc = 0, aw_acc = 0;
    bit aw_gate = 0, rnd = 0, running = 0;

    beat_t mq[$];
    int m_state = 0, m_cnt = 0, m_len = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic add_burst(input int len, input logic [2:0] size, input logic [1:0] bt,
                             input logic [IW-1:0] id, input int last_pos, input logic [SW-1:0] k0);
        aw_t a;
        b_t b;
        a.len = 8'(len); a.size = size; a.bt = bt; a.id = id;
        aq.push_back(a);
        for (int i = 0; i <= len; i++) begin
            beat_t x, e;
            x.d = {$urandom, $urandom};
            x.k = (i == 0) ? k0 : SW'($urandom);
            x.l = (i == last_pos);
            wq.push_back(x);
            e = x; e.l = (i == len);
            es.push_back(e);
        end
        b.id = id;
        b.resp = (last_pos != len || size > 3'd3 || bt == 2'b11) ? 2'b10 : 2'b00;
        eb.push_back(b);
    endtask

    // Model advance and fire checks at the rising edge.
    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            mq.delete(); m_state = 0; m_cnt = 0; m_len = 0;
        end else begin
            int st;
            bit mpush, mpop;
            st = m_state;
            mpush = w_valid && (mq.size() < DEPTH);
            mpop  = (st == 1) && (mq.size() > 0) && s_ready;
            if (s_valid && s_ready) begin
                beat_t e;
                if (es.size() == 0) chk("R5 extra stream beat", 1, 0);
                else begin
                    e = es.pop_front();
                    chk("R4 stream data", s_data, e.d);
                    chk("R4 stream keep", 64'(s_keep), 64'(e.k));
                    chk("R5 stream last", 64'(s_last), 64'(e.l));
                end
            end
            if (b_valid && b_ready) begin
                b_t e;
                if (eb.size() == 0) chk("R6 extra response", 1, 0);
                else begin
                    e = eb.pop_front();
                    chk("R6 R7 response code", 64'(b_resp), 64'(e.resp));
                    chk("R10 response tag", 64'(b_id), 64'(e.id));
                end
                b_done++;
            end
            if (w_valid && w_ready) begin wi++; w_acc = 1; end
            if (aw_valid && aw_ready) begin ai++; aw_acc = 1; end
            if (mpop) begin
                void'(mq.pop_front());
                if (m_cnt == m_len) m_state = 2; else m_cnt++;
            end
            if (mpush) mq.push_back('{w_data, w_strb, w_last});
            if (st == 0 && aw_valid) begin m_len = int'(aw_len); m_cnt = 0; m_state = 1; end
            if (st == 2 && b_ready) m_state = 0;
        end
    end

    // Compare against the model, then drive new inputs, at the falling edge.
    always @(negedge clk) begin
        if (running) begin
            chk("R8 aw_ready", 64'(aw_ready), 64'(m_state == 0));
            chk("R2 R9 w_ready", 64'(w_ready), 64'(mq.size() < DEPTH));
            chk("R3 R1 s_valid", 64'(s_valid), 64'(m_state == 1 && mq.size() > 0));
            chk("R6 b_valid", 64'(b_valid), 64'(m_state == 2));
            if (m_state == 1 && mq.size() > 0) begin
                chk("R4 head data", s_data, mq[0].d);
                chk("R5 head last", 64'(s_last), 64'(m_cnt == m_len));
            end
            if (!w_valid || w_acc) begin
                w_acc = 0;
                if (wi < wq.size() && (!rnd || ($urandom % 4 != 0))) begin
                    w_valid = 1; w_data = wq[wi].d; w_strb = wq[wi].k; w_last = wq[wi].l;
                end else w_valid = 0;
            end
            if (!aw_valid || aw_acc) begin
                aw_acc = 0;
                if (aw_gate && ai < aq.size() && (!rnd || ($urandom % 3 != 0))) begin
                    aw_valid = 1; aw_len = aq[ai].len; aw_size = aq[ai].size;
                    aw_burst = aq[ai].bt; aw_id = aq[ai].id;
                end else aw_valid = 0;
            end
            s_ready = rnd ? 1'($urandom % 2) : 1'b1;
            b_ready = rnd ? 1'($urandom % 2) : 1'b1;
        end
    end

    always @(posedge clk) begin
        if (cyc >= 150000) begin
            bad++; total++;
            $display("FAIL watchdog expired actual=%0d expected=%0d responses", b_done, aq.size());
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        add_burst(0, 3'd3, 2'b01, 4'h1, 0, 8'hff);
        add_burst(3, 3'd3, 2'b01, 4'h2, 3, 8'h19);
        add_burst(5, 3'd3, 2'b01, 4'h3, 2, 8'h01);
        add_burst(1, 3'd4, 2'b01, 4'h4, 1, 8'h80);
        add_burst(2, 3'd3, 2'b11, 4'h5, 2, 8'h0f);
        add_burst(7, 3'd2, 2'b00, 4'h6, 7, 8'hf0);
        add_burst(0, 3'd3, 2'b10, 4'h7, -1, 8'h42);
        for (int n = 0; n < 12; n++) begin
            int ln;
            ln = int'($urandom % 9);
            add_burst(ln, 3'd3, 2'b01, IW'(n), ln, SW'($urandom));
        end

        repeat (3) @(posedge clk);
        rst = 0;
        @(negedge clk);
        chk("R11 reset aw_ready", 64'(aw_ready), 1);
        chk("R11 reset w_ready", 64'(w_ready), 1);
        chk("R11 reset s_valid", 64'(s_valid), 0);
        chk("R11 reset b_valid", 64'(b_valid), 0);
        running = 1;

        // Data before address: buffer fills, nothing forwarded.
        repeat (8) @(negedge clk);
        chk("R2 beats taken early", 64'(wi), 64'(DEPTH));
        chk("R2 w_ready low when full", 64'(w_ready), 0);
        chk("R3 no stream before address", 64'(s_valid), 0);
        aw_gate = 1;
        wait (b_done >= 2);

        // Random valid and ready on every channel.
        rnd = 1;
        wait (b_done >= aq.size());
        repeat (4) @(negedge clk);
        running = 0;
        chk("R5 all stream beats seen", 64'(es.size()), 0);
        chk("R6 all responses seen", 64'(eb.size()), 0);
        chk("R8 idle at end", 64'(aw_ready), 1);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule